// File: doc/BRIEF.md
# Two-Wire Device-Side Byte Transmitter

This block sends a single byte from a peripheral to a host across a two-wire, open-collector clock/data link. On this link the peripheral generates the clock. A one-cycle strobe hands the byte to the block. The block then waits until both the clock and data lines are sampled high. Once they are, it drives an eleven-bit frame by pulling the lines low through open-drain enables.

The host may take the link back at any point. It does this by holding the clock low while the block is releasing it. If this happens before the rising edge of the tenth clock, the block drops both lines, pulses an abort flag and keeps the byte. It sends the byte again as soon as both lines are idle-high once more. A clock-low seen after the tenth rising edge is ignored, and the frame runs through its stop bit. A one-cycle done pulse marks delivery. The clock phase timing comes from a one-microsecond tick supplied from outside the block.

Top module: `ps2_dev_tx`

## Requirements
- R1: While reset is asserted and after it is released, both pull enables are low and `busy`, `done` and `aborted` are low until a byte is accepted.
- R2: While the sampled clock line is low, no frame starts: no clock pulse and no data pull are produced. `busy` stays high with the byte pending.
- R3: While the clock line is high and the data line is low, no frame starts. The frame begins only once both lines are sampled high.
- R4: A frame has exactly 11 clock pulses, and the data line is read at each falling clock edge, with a pulled-low line meaning 0. Frame position 0 is the start bit (0). Positions 1 to 8 carry data bits 0 to 7, least significant first. Position 9 is odd parity over the 8 data bits, and position 10 is the stop bit (1).
- R5: Each data value changes only while the clock is high. It holds from before the falling edge until after the following rising edge.
- R6: Every clock low phase and every clock high phase between pulses lasts `HALF_US` microsecond ticks (default 40).
- R7: While the block releases the clock during a frame, after a settle time of `SETTLE_US` ticks, it checks the clock line on every cycle. If it finds the line low before the tenth rising edge, it releases both lines on the next cycle and pulses `aborted` for exactly one cycle, and `done` does not pulse.
- R8: After an abort the byte is kept and `busy` stays high. The same byte is sent again, as a complete frame, once both lines are sampled high again.
- R9: A clock-low forced by the host after the tenth rising edge does not abort the frame. The frame completes with its stop bit.
- R10: `done` pulses for one cycle after the rising edge of the eleventh clock, never together with `aborted`. `busy` is low from that cycle on.
- R11: A send strobe while `busy` is high is ignored. The byte being sent is unchanged, and no further frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| tx_send | input | 1 | Strobe that accepts `tx_byte` when idle |
| tx_byte | input | 8 | Byte to transmit |
| clk_in | input | 1 | Sampled level of the link clock line |
| dat_in | input | 1 | Sampled level of the link data line |
| clk_pull | output | 1 | Pull the clock line low when high |
| dat_pull | output | 1 | Pull the data line low when high |
| busy | output | 1 | A byte is pending or being sent |
| done | output | 1 | One-cycle pulse: frame delivered |
| aborted | output | 1 | One-cycle pulse: frame abandoned on contention |

## Verification
The bench aims contention at both sides of the tenth-clock boundary, in the high phase of parity and in the high phase of stop. A design with the limit off by one would either deliver a frame the host had already claimed or throw away a frame that was already committed. Held-low clock and request-to-send states are applied before a start, to catch a transmitter that checks only one line. After an abort, the retried frame is decoded in full, which shows up a design that loses or reloads the byte. Parity is checked with all-zero, all-one and mixed bytes, and a send strobe given during a frame must leave that frame untouched.

// File: rtl/ps2tx_pkg.sv
// Shared types for the device-side transmitter.
// Assumes: nothing beyond the standard language.
package ps2tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,      // nothing pending
        ST_WAIT_BUS,  // byte held, waiting for both lines high
        ST_HIGH,      // clock released, data set mid-phase
        ST_LOW        // clock pulled low
    } tx_state_t;
endpackage

// File: rtl/ps2tx_phase_timer.sv
// Phase timer: counts microsecond ticks inside one clock phase.
// Gives a mid-phase strobe, an end-of-phase strobe and a settle flag.
// Assumes: us_tick is a single-cycle pulse; run low holds the count at zero.
module ps2tx_phase_timer #(
    parameter int HALF_US   = 40,
    parameter int SETTLE_US = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic us_tick,
    output logic mid,
    output logic phase_end,
    output logic settled
);
    localparam int CNT_W   = $clog2(HALF_US + 1);
    localparam int MID_AT  = HALF_US / 2 - 1;
    localparam int LAST_AT = HALF_US - 1;

    logic [CNT_W-1:0] cnt_q;

    // Strobes decoded from the tick count.
    always_comb begin
        mid       = run && us_tick && (cnt_q == CNT_W'(MID_AT));
        phase_end = run && us_tick && (cnt_q == CNT_W'(LAST_AT));
        settled   = (cnt_q >= CNT_W'(SETTLE_US));
    end

    // Tick counter that wraps at the end of each phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (phase_end) begin
            cnt_q <= '0;
        end else if (us_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ps2tx_frame.sv
// Frame holder: keeps the byte, builds start/data/parity/stop bits and
// tracks the position of the bit on the wire.
// Assumes: load only while idle; the byte persists across aborts.
module ps2tx_frame #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              idx_clr,
    input  logic              idx_inc,
    output logic              cur_bit,
    output logic              at_last,
    output logic              before_tenth
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam int PAR_POS = DATA_W + 1;
    localparam int STP_POS = DATA_W + 2;

    logic [DATA_W-1:0]  byte_q;
    logic [IDX_W-1:0]   idx_q;
    logic [FRAME_W-1:0] frame;

    // Start bit, odd parity and stop bit.
    always_comb begin
        frame[0]       = 1'b0;
        frame[PAR_POS] = ~^byte_q;
        frame[STP_POS] = 1'b1;
    end

    // Data bits, least significant first.
    for (genvar g = 0; g < DATA_W; g++) begin : g_data
        assign frame[g + 1] = byte_q[g];
    end

    // Current bit and position flags.
    always_comb begin
        cur_bit      = frame[idx_q];
        at_last      = (idx_q == IDX_W'(STP_POS));
        before_tenth = (idx_q < IDX_W'(STP_POS));
    end

    // Byte register, kept until the next accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (load) begin
            byte_q <= load_byte;
        end
    end

    // Bit position counter.
    always_ff @(posedge clk) begin
        if (!rst_n || idx_clr) begin
            idx_q <= '0;
        end else if (idx_inc) begin
            idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/ps2tx_ctrl.sv
// Sequencer: gates the start on an idle bus, alternates clock phases,
// drives data mid-high-phase, and aborts on early host contention.
// Assumes: clk_in and dat_in are already synchronised line levels.
module ps2tx_ctrl
    import ps2tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_send,
    input  logic clk_in,
    input  logic dat_in,
    input  logic mid,
    input  logic phase_end,
    input  logic settled,
    input  logic cur_bit,
    input  logic at_last,
    input  logic before_tenth,
    output logic load,
    output logic idx_clr,
    output logic idx_inc,
    output logic run,
    output logic clk_pull,
    output logic dat_pull,
    output logic busy,
    output logic done,
    output logic aborted
);
    tx_state_t state_q;
    logic      contend;

    // Control strobes to the timer and the frame holder.
    always_comb begin
        load    = (state_q == ST_IDLE) && tx_send;
        idx_clr = (state_q == ST_WAIT_BUS);
        idx_inc = (state_q == ST_LOW) && phase_end && !at_last;
        run     = (state_q == ST_HIGH) || (state_q == ST_LOW);
        busy    = (state_q != ST_IDLE);
        contend = (state_q == ST_HIGH) && settled && !clk_in && before_tenth;
    end

    // State, line enables and the result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            clk_pull <= 1'b0;
            dat_pull <= 1'b0;
            done     <= 1'b0;
            aborted  <= 1'b0;
        end else begin
            done    <= 1'b0;
            aborted <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (tx_send) state_q <= ST_WAIT_BUS;
                end
                ST_WAIT_BUS: begin
                    if (clk_in && dat_in) state_q <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (contend) begin
                        state_q  <= ST_WAIT_BUS;
                        dat_pull <= 1'b0;
                        aborted  <= 1'b1;
                    end else begin
                        if (mid) dat_pull <= !cur_bit;
                        if (phase_end) begin
                            clk_pull <= 1'b1;
                            state_q  <= ST_LOW;
                        end
                    end
                end
                ST_LOW: begin
                    if (phase_end) begin
                        clk_pull <= 1'b0;
                        if (at_last) begin
                            state_q  <= ST_IDLE;
                            dat_pull <= 1'b0;
                            done     <= 1'b1;
                        end else begin
                            state_q <= ST_HIGH;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ps2_dev_tx.sv
// Top level: device-side byte transmitter for a two-wire clock/data link.
// Connects the phase timer, the frame holder and the sequencer.
// Assumes: external pull-ups; line inputs are synchronised by the caller.
module ps2_dev_tx #(
    parameter int DATA_W    = 8,
    parameter int HALF_US   = 40,
    parameter int SETTLE_US = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              tx_send,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              clk_in,
    input  logic              dat_in,
    output logic              clk_pull,
    output logic              dat_pull,
    output logic              busy,
    output logic              done,
    output logic              aborted
);
    logic load, idx_clr, idx_inc, run;
    logic mid, phase_end, settled;
    logic cur_bit, at_last, before_tenth;

    ps2tx_phase_timer #(
        .HALF_US  (HALF_US),
        .SETTLE_US(SETTLE_US)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .us_tick  (us_tick),
        .mid      (mid),
        .phase_end(phase_end),
        .settled  (settled)
    );

    ps2tx_frame #(
        .DATA_W(DATA_W)
    ) frame_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .load_byte   (tx_byte),
        .idx_clr     (idx_clr),
        .idx_inc     (idx_inc),
        .cur_bit     (cur_bit),
        .at_last     (at_last),
        .before_tenth(before_tenth)
    );

    ps2tx_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_send     (tx_send),
        .clk_in      (clk_in),
        .dat_in      (dat_in),
        .mid         (mid),
        .phase_end   (phase_end),
        .settled     (settled),
        .cur_bit     (cur_bit),
        .at_last     (at_last),
        .before_tenth(before_tenth),
        .load        (load),
        .idx_clr     (idx_clr),
        .idx_inc     (idx_inc),
        .run         (run),
        .clk_pull    (clk_pull),
        .dat_pull    (dat_pull),
        .busy        (busy),
        .done        (done),
        .aborted     (aborted)
    );
endmodule

// File: rtl/ps2_dev_tx_chk.sv
// Checker for the transmitter's port-level rules, bound to the top.
// Assumes: synchronous active-low reset.
module ps2_dev_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic clk_pull,
    input logic dat_pull,
    input logic busy,
    input logic done,
    input logic aborted
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!clk_pull && !dat_pull));                         // R1
    AST_DATA_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_pull && $past(clk_pull)) |-> $stable(dat_pull));         // R5
    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        aborted |=> !aborted);                                        // R7
    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        aborted |-> (!clk_pull && !dat_pull && busy));                // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                              // R10
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !aborted));                                // R10
endmodule

bind ps2_dev_tx ps2_dev_tx_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_pull(clk_pull),
    .dat_pull(dat_pull),
    .busy    (busy),
    .done    (done),
    .aborted (aborted)
);

// File: tb/ps2_dev_tx_tb_top.sv
`timescale 1ns/1ps
// Directed bench: a host-side line model, a frame decoder and one task per scenario.
module ps2_dev_tx_tb_top;
    localparam int TICK_DIV = 4;
    localparam int HALF_US  = 40;
    localparam int HP       = HALF_US * TICK_DIV;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0;
    logic tx_send = 1'b0;
    logic [7:0] tx_byte = '0;
    logic host_clk_low = 1'b0;
    logic host_dat_low = 1'b0;
    logic clk_pull, dat_pull, busy, done, aborted;
    logic clk_line, dat_line;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_all = 0;
    int tick_cnt = 0;

    // Monitor state.
    int   falls = 0, rises = 0, cyc = 0;
    int   hold_err = 0, len_err = 0, done_cnt = 0, abort_cnt = 0;
    logic prev_cp = 1'b0;
    logic bits [0:15];

    assign clk_line = !(clk_pull || host_clk_low);
    assign dat_line = !(dat_pull || host_dat_low);

    always #2.5 clk = ~clk;

    ps2_dev_tx #(.DATA_W(8), .HALF_US(HALF_US), .SETTLE_US(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .tx_send(tx_send),
        .tx_byte(tx_byte), .clk_in(clk_line), .dat_in(dat_line),
        .clk_pull(clk_pull), .dat_pull(dat_pull), .busy(busy),
        .done(done), .aborted(aborted)
    );

    // Microsecond tick every TICK_DIV clocks.
    always @(posedge clk) begin
        tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
        us_tick  <= (tick_cnt == TICK_DIV - 1);
    end

    // Decoder of the device clock edges and result pulses.
    always @(negedge clk) begin
        cyc++;
        if (clk_pull && !prev_cp) begin
            if (falls < 16) bits[falls] = dat_line;
            if (falls > 0 && cyc != HP) len_err++;
            falls++;
            cyc = 0;
        end else if (!clk_pull && prev_cp) begin
            if (falls > 0 && dat_line !== bits[falls - 1]) hold_err++;
            if (cyc != HP) len_err++;
            rises++;
            cyc = 0;
        end
        if (done) done_cnt++;
        if (aborted) abort_cnt++;
        prev_cp = clk_pull;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc_all++;
        if (cyc_all > WD_LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc_all, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
        #0.2;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic mon_clear();
        falls = 0; rises = 0; hold_err = 0; len_err = 0;
        done_cnt = 0; abort_cnt = 0;
    endtask

    function automatic logic exp_bit(input logic [7:0] b, input int i);
        if (i == 0) return 1'b0;
        if (i <= 8) return b[i - 1];
        if (i == 9) return ~^b;
        return 1'b1;
    endfunction

    task automatic send(input logic [7:0] b);
        tx_byte = b;
        tx_send = 1'b1;
        step();
        tx_send = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000 && done_cnt == 0; i++) step();
        step();
    endtask

    // Compare a decoded frame with the expected one.
    task automatic check_frame(input string req, input logic [7:0] b);
        int bad = 0;
        for (int i = 0; i < 11; i++) if (bits[i] !== exp_bit(b, i)) bad++;
        check({req, " clock count"}, falls, 11);
        check({req, " bad frame bits"}, bad, 0);
    endtask

    task automatic t_reset();
        check("R1 outputs at reset", int'({clk_pull, dat_pull, busy, done, aborted}), 0);
    endtask

    task automatic t_normal(input logic [7:0] b);
        mon_clear();
        send(b);
        check("R10 busy after accept", int'(busy), 1);
        wait_done();
        check_frame("R4", b);
        check("R5 hold errors", hold_err, 0);
        check("R6 phase length errors", len_err, 0);
        check("R10 done pulses", done_cnt, 1);
        check("R10 busy after done", int'(busy), 0);
    endtask

    task automatic t_inhibit();
        mon_clear();
        host_clk_low = 1'b1;
        send(8'h3C);
        wait_n(400);
        check("R2 no clock while inhibited", falls, 0);
        check("R2 no data pull while inhibited", int'(dat_pull), 0);
        check("R2 pending busy", int'(busy), 1);
        host_clk_low = 1'b0;
        wait_done();
        check_frame("R2", 8'h3C);
    endtask

    task automatic t_rts();
        mon_clear();
        host_dat_low = 1'b1;
        send(8'h81);
        wait_n(400);
        check("R3 no clock during request", falls, 0);
        check("R3 pending busy", int'(busy), 1);
        host_dat_low = 1'b0;
        wait_done();
        check_frame("R3", 8'h81);
    endtask

    // Host pulls clock low in the high phase after the n-th rising edge.
    task automatic t_contend(input logic [7:0] b, input int n, input bit expect_abort);
        int f_before;
        mon_clear();
        send(b);
        for (int i = 0; i < 20000 && rises < n; i++) step();
        wait_n(40);
        host_clk_low = 1'b1;
        wait_n(3);
        if (expect_abort) begin
            check("R7 abort pulse", abort_cnt, 1);
            check("R7 lines released", int'({clk_pull, dat_pull}), 0);
            check("R7 no done on abort", done_cnt, 0);
            check("R8 still busy", int'(busy), 1);
            f_before = falls;
            wait_n(400);
            check("R8 no clock while held", falls, f_before);
            host_clk_low = 1'b0;
            mon_clear();
            wait_done();
            check_frame("R8 retry", b);
        end else begin
            wait_n(20);
            host_clk_low = 1'b0;
            wait_done();
            check("R9 no abort late", abort_cnt, 0);
            check_frame("R9", b);
            check("R9 done pulses", done_cnt, 1);
        end
    endtask

    task automatic t_busy_ignore();
        mon_clear();
        send(8'h5A);
        for (int i = 0; i < 20000 && falls < 2; i++) step();
        send(8'hC3);
        wait_done();
        check_frame("R11", 8'h5A);
        wait_n(400);
        check("R11 idle after frame", int'(busy), 0);
        check("R11 no extra frame", falls, 11);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) bits[i] = 1'b0;
        wait_n(5);
        t_reset();
        rst_n = 1'b1;
        wait_n(5);
        t_reset();
        t_normal(8'hA5);
        t_normal(8'h00);
        t_normal(8'hFF);
        t_inhibit();
        t_rts();
        t_contend(8'h96, 3, 1'b1);
        t_contend(8'h4E, 9, 1'b1);
        t_contend(8'h27, 10, 1'b0);
        t_busy_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule